// File: doc/BRIEF.md
# Stop-Mode Wakeup Sequencer

This block takes a small processor core into a low-power stop state and brings it back out in a fixed order. A one-cycle stop request, sampled while no unmasked interrupt is pending, makes the block drop the main oscillator enable and hold the core. The low-speed oscillator is also dropped, unless a watchdog configuration input asks for it to keep running. The block then waits for an interrupt request whose mask bit is clear.

When such a request arrives, the main oscillator is enabled again. If the core was clocked from the external high-speed oscillator, a stabilization counter runs for a count picked by a 3-bit selection input. A short fixed wait follows. The core is then released, either into vectored interrupt servicing or on to the instruction after the stop, depending on the global interrupt enable. A thermometer-coded status output shows how far the stabilization counter has climbed, so software can check it before moving the CPU clock onto the external oscillator.

Top module: `stopwake_seq`

## Requirements
- R1: While stopped, an interrupt request whose mask bit is 0 makes `main_osc_en` return to 1 on the next clock edge, and this starts the wakeup.
- R2: While stopped, requests whose mask bit is 1 have no effect: `core_halt` stays 1 and `main_osc_en` stays 0.
- R3: With `clk_ext`=1, the core stays halted while a stabilization count of T = 2^E cycles runs. E = BASE_EXP + s for selection s < 4, and E = BASE_EXP + 2s - 4 for s ≥ 4. With the default BASE_EXP = 8, this gives 2^8 through 2^18.
- R4: After stabilization a fixed wait of WAIT_CYC (default 3) cycles follows. With `clk_ext`=1, `release_pulse` rises after edge number T + WAIT_CYC + 1, where edge 1 is the edge that samples the unmasked request.
- R5: With `clk_ext`=0, the stabilization count is skipped. `release_pulse` rises after edge WAIT_CYC + 1, and the status stays 0.
- R6: Together with `release_pulse`, `take_irq` is 1 if `irq_enable` was 1 at the releasing edge. Otherwise `resume_next` is 1 instead. Exactly one of the two is set.
- R7: Bit k of `stab_status` is 1 when the stabilization count is at least 2^E(k). The code is a thermometer from bit 0 upward. The count starts at 0 on stop entry, rises once per cycle after an external-oscillator wakeup, and stops rising at 2^E(7), which gives all ones.
- R8: While stopped, `lsosc_en` is 0 only if `wdt_keep` is 0. If `wdt_keep` is 1, it stays 1.
- R9: A synchronous active-low reset returns the block to run state: `core_halt`=0, both oscillator enables 1, status 0, no pulses.
- R10: A stop request that arrives while an unmasked request is pending is ignored. `core_halt` stays 0 and the main oscillator stays on.
- R11: `release_pulse` is high for exactly one cycle per wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | One-cycle request to enter stop |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_mask | input | NUM_IRQ | Mask per request line, 1 = masked |
| irq_enable | input | 1 | Global interrupt acknowledge enable |
| stab_sel | input | SEL_W | Stabilization count selection |
| clk_ext | input | 1 | 1 when the CPU runs from the external oscillator |
| wdt_keep | input | 1 | Watchdog keeps running in standby |
| core_halt | output | 1 | Core held (not in run state) |
| main_osc_en | output | 1 | Main oscillator enable |
| lsosc_en | output | 1 | Low-speed oscillator enable |
| release_pulse | output | 1 | One-cycle mark of core release |
| take_irq | output | 1 | Release goes to vectored interrupt servicing |
| resume_next | output | 1 | Release continues at the next instruction |
| stab_status | output | 2**SEL_W | Thermometer progress of the stabilization count |

## Verification
An off-by-one in the stabilization counter or in the fixed-wait counter moves the release edge by a cycle. The bench sees this at once, because it counts edges from the waking request to `release_pulse` for every selection and both clock sources. A bad state transition shows within one cycle of the stop or wake stimulus, as a wrong `core_halt` or oscillator enable. A stale or miscleared count shows in the status value latched at release, or in the saturated value read thousands of cycles later.

// File: rtl/swk_pkg.sv
package swk_pkg;

   typedef enum logic [1:0] {
      SW_RUN  = 2'd0,
      SW_STOP = 2'd1,
      SW_STAB = 2'd2,
      SW_WAIT = 2'd3
   } swk_state_e;

   // exponent of the stabilization count for selection value sel
   function automatic int unsigned stab_exp(input int unsigned base, input int unsigned sel);
      return (sel < 4) ? base + sel : base + 2 * sel - 4;
   endfunction

endpackage

// File: rtl/swk_irq_detect.sv
module swk_irq_detect #(
   parameter int unsigned NUM_IRQ = 8
) (
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_mask,
   output logic               pend
);

   if (NUM_IRQ < 1) begin : g_bad_num
      $error("swk_irq_detect: NUM_IRQ must be at least 1");
   end

   logic [NUM_IRQ-1:0] hit;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign hit[i] = irq_req[i] & ~irq_mask[i];
   end

   assign pend = |hit;

endmodule

// File: rtl/swk_stab_count.sv
module swk_stab_count #(
   parameter int unsigned BASE_EXP = 8,
   parameter int unsigned SEL_W    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  start,
   input  logic [SEL_W-1:0]      sel,
   output logic                  last,
   output logic [(1<<SEL_W)-1:0] status
);

   localparam int unsigned NSEL    = 1 << SEL_W;
   localparam int unsigned MAX_EXP = swk_pkg::stab_exp(BASE_EXP, NSEL - 1);
   localparam int unsigned CNT_W   = MAX_EXP + 1;
   localparam logic [CNT_W-1:0] MAXC = CNT_W'(1) << MAX_EXP;

   if (SEL_W != 3) begin : g_bad_sel
      $error("swk_stab_count: the selection field must be 3 bits wide");
   end
   if (BASE_EXP < 1) begin : g_bad_base
      $error("swk_stab_count: BASE_EXP must be at least 1");
   end

   logic             active;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] thr [NSEL];
   logic [CNT_W-1:0] tgt;

   for (genvar k = 0; k < NSEL; k++) begin : g_thr
      localparam int unsigned E = swk_pkg::stab_exp(BASE_EXP, k);
      assign thr[k]    = CNT_W'(1) << E;
      assign status[k] = (cnt >= thr[k]);
   end

   assign tgt  = thr[sel];
   assign last = active && (cnt == tgt - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (clr) begin
         active <= 1'b0;
         cnt    <= '0;
      end else begin
         if (start) active <= 1'b1;
         if (active && cnt != MAXC) cnt <= cnt + CNT_W'(1);
      end
   end

   p_status_therm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status & (status + NSEL'(1))) == '0);

   p_status_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> status >= $past(status));

   p_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> status == '0);

endmodule

// File: rtl/swk_wait_timer.sv
module swk_wait_timer #(
   parameter int unsigned WAIT_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);

   localparam int unsigned WW = $clog2(WAIT_CYC + 1);

   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("swk_wait_timer: WAIT_CYC must be at least 1");
   end

   if (WAIT_CYC == 1) begin : g_single
      assign last = run;
   end else begin : g_count
      logic [WW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n || !run) cnt <= '0;
         else                cnt <= cnt + WW'(1);
      end

      assign last = run && (cnt == WW'(WAIT_CYC - 1));

      p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
         run |-> cnt < WW'(WAIT_CYC));
   end

endmodule

// File: rtl/stopwake_seq.sv
module stopwake_seq #(
   parameter int unsigned NUM_IRQ       = 8,
   parameter int unsigned SEL_W         = 3,
   parameter int unsigned BASE_EXP      = 8,
   parameter int unsigned WAIT_CYC      = 3,
   parameter bit          SKIP_STAB_INT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stop_req,
   input  logic [NUM_IRQ-1:0]    irq_req,
   input  logic [NUM_IRQ-1:0]    irq_mask,
   input  logic                  irq_enable,
   input  logic [SEL_W-1:0]      stab_sel,
   input  logic                  clk_ext,
   input  logic                  wdt_keep,
   output logic                  core_halt,
   output logic                  main_osc_en,
   output logic                  lsosc_en,
   output logic                  release_pulse,
   output logic                  take_irq,
   output logic                  resume_next,
   output logic [(1<<SEL_W)-1:0] stab_status
);

   import swk_pkg::*;

   swk_state_e state, nxt;
   logic pend, use_stab, stab_last, wait_last;
   logic cnt_clr, cnt_start, rel_now;
   logic rel_q, take_q, resume_q;

   if (SKIP_STAB_INT) begin : g_skip_int
      assign use_stab = clk_ext;
   end else begin : g_always_stab
      assign use_stab = 1'b1;
   end

   swk_irq_detect #(.NUM_IRQ(NUM_IRQ)) u_irq (
      .irq_req (irq_req),
      .irq_mask(irq_mask),
      .pend    (pend)
   );

   always_comb begin
      nxt = state;
      unique case (state)
         SW_RUN:  if (stop_req && !pend) nxt = SW_STOP;
         SW_STOP: if (pend)              nxt = use_stab ? SW_STAB : SW_WAIT;
         SW_STAB: if (stab_last)         nxt = SW_WAIT;
         SW_WAIT: if (wait_last)         nxt = SW_RUN;
         default:                        nxt = SW_RUN;
      endcase
   end

   assign cnt_clr   = (nxt == SW_STOP);
   assign cnt_start = (state == SW_STOP) && (nxt == SW_STAB);
   assign rel_now   = (state == SW_WAIT) && wait_last;

   swk_stab_count #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_stab (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .start (cnt_start),
      .sel   (stab_sel),
      .last  (stab_last),
      .status(stab_status)
   );

   swk_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == SW_WAIT),
      .last (wait_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SW_RUN;
         rel_q    <= 1'b0;
         take_q   <= 1'b0;
         resume_q <= 1'b0;
      end else begin
         state    <= nxt;
         rel_q    <= rel_now;
         take_q   <= rel_now & irq_enable;
         resume_q <= rel_now & ~irq_enable;
      end
   end

   assign core_halt     = (state != SW_RUN);
   assign main_osc_en   = (state != SW_STOP);
   assign lsosc_en      = (state != SW_STOP) | wdt_keep;
   assign release_pulse = rel_q;
   assign take_irq      = take_q;
   assign resume_next   = resume_q;

   p_wake_osc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_osc_en && pend) |=> main_osc_en);

   p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_osc_en && !pend) |=> (!main_osc_en && core_halt));

   p_release_after_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      release_pulse |-> (!core_halt && $past(core_halt) && $past(main_osc_en)));

   p_route_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      release_pulse |-> (take_irq != resume_next));

   p_route_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
      release_pulse |-> (take_irq == $past(irq_enable)));

   p_lsosc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_osc_en && wdt_keep) |-> lsosc_en);

   p_stop_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_halt && stop_req && pend) |=> !core_halt);

   p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      release_pulse |=> !release_pulse);

endmodule

// File: tb/sim_stopwake_seq.sv
`timescale 1ns/1ps
module sim_stopwake_seq;

   localparam int unsigned NI = 4;
   localparam int unsigned BE = 2;
   localparam int unsigned WC = 3;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       stop_req;
   logic [NI-1:0] irq_req, irq_mask;
   logic       irq_enable, clk_ext, wdt_keep;
   logic [2:0] stab_sel;
   logic       core_halt, main_osc_en, lsosc_en, release_pulse, take_irq, resume_next;
   logic [7:0] stab_status;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   stopwake_seq #(.NUM_IRQ(NI), .SEL_W(3), .BASE_EXP(BE), .WAIT_CYC(WC), .SKIP_STAB_INT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_req(irq_req), .irq_mask(irq_mask),
      .irq_enable(irq_enable), .stab_sel(stab_sel), .clk_ext(clk_ext), .wdt_keep(wdt_keep),
      .core_halt(core_halt), .main_osc_en(main_osc_en), .lsosc_en(lsosc_en),
      .release_pulse(release_pulse), .take_irq(take_irq), .resume_next(resume_next),
      .stab_status(stab_status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int unsigned exp_of(input int unsigned k);
      return (k < 4) ? BE + k : BE + 2 * k - 4;
   endfunction

   function automatic logic [7:0] therm(input int unsigned c);
      logic [7:0] t = '0;
      for (int k = 0; k < 8; k++) if (c >= (1 << exp_of(k))) t[k] = 1'b1;
      return t;
   endfunction

   task automatic do_wake(input int unsigned sel, input bit ext, input bit ie_v,
                          input int unsigned line, input bit wdt);
      int unsigned n, tcnt, expect_n;
      bit got;
      int unsigned other = (line + 1) % NI;
      tcnt = 1 << exp_of(sel);
      @(negedge clk);
      stab_sel = 3'(sel); clk_ext = ext; irq_enable = ie_v; wdt_keep = wdt;
      irq_mask = '0; irq_mask[other] = 1'b1; stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      chk("R8 lsosc_en in stop", lsosc_en, wdt);
      chk("R2 main osc off in stop", main_osc_en, 0);
      chk("R7 status cleared on stop", stab_status, 0);
      irq_req[other] = 1'b1;
      repeat (4) @(negedge clk);
      chk("R2 masked request keeps halt", core_halt, 1);
      chk("R2 masked request keeps osc off", main_osc_en, 0);
      irq_req[line] = 1'b1;
      n = 0; got = 1'b0;
      while (!got && n < 6000) begin
         @(negedge clk);
         n++;
         if (n == 1) chk("R1 unmasked request enables osc", main_osc_en, 1);
         if (release_pulse) got = 1'b1;
      end
      expect_n = ext ? tcnt + WC + 1 : WC + 1;
      if (ext) chk("R3 R4 release edge external", n, expect_n);
      else     chk("R5 release edge internal", n, expect_n);
      chk("R6 take_irq", take_irq, ie_v);
      chk("R6 resume_next", resume_next, !ie_v);
      chk("R7 status at release", stab_status, ext ? therm(tcnt + WC) : 8'h00);
      @(negedge clk);
      chk("R11 release pulse single", release_pulse, 0);
      chk("R4 core running after release", core_halt, 0);
      irq_req = '0; irq_mask = '0;
   endtask

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R4 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; stop_req = 1'b0; irq_req = '0; irq_mask = '0;
      irq_enable = 1'b0; clk_ext = 1'b0; wdt_keep = 1'b0; stab_sel = '0;
      repeat (3) @(negedge clk);
      chk("R9 reset core_halt", core_halt, 0);
      chk("R9 reset main_osc_en", main_osc_en, 1);
      chk("R9 reset lsosc_en", lsosc_en, 1);
      chk("R9 reset status", stab_status, 0);
      chk("R9 reset pulse", release_pulse, 0);
      rst_n = 1'b1;

      for (int s = 0; s < 8; s++)
         for (int e = 0; e < 2; e++)
            for (int i = 0; i < 2; i++)
               do_wake(s, e[0], i[0], (s + i) % NI, e[0] ^ i[0]);

      // R7 saturation: count keeps climbing after release until all ones
      do_wake(0, 1'b1, 1'b1, 0, 1'b0);
      repeat (4200) @(negedge clk);
      chk("R7 status saturates", stab_status, 8'hFF);

      // R10 stop while an unmasked request is pending
      @(negedge clk);
      irq_req[2] = 1'b1; stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      chk("R10 stop ignored halt", core_halt, 0);
      chk("R10 stop ignored osc", main_osc_en, 1);
      chk("R10 status kept", stab_status, 8'hFF);
      @(negedge clk);
      chk("R10 no release pulse", release_pulse, 0);
      irq_req = '0;

      // R9 reset while stopped
      @(negedge clk);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      chk("R9 stop before reset", core_halt, 1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R9 reset from stop halt", core_halt, 0);
      chk("R9 reset from stop osc", main_osc_en, 1);
      chk("R9 reset from stop status", stab_status, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule